// File: doc/BRIEF.md
# Cache Line Flit Packetizer

This block moves one whole cache line across a single point-to-point network link. On the sending side it takes a 512-bit line together with a destination tile id, a source core id and a one-bit request/response opcode. It then emits a packet of typed flits, one per cycle: a head flit with the routing fields, one body flit for each flit-wide slice of the line, and a tail flit that closes the packet. Each transfer uses a valid/ready handshake, so the link may hold the sender back on any cycle.

On the receiving side the flit train is checked against the expected framing. Every flit the link presents is taken at once. The line is rebuilt from the body flits, and the header fields are latched from the head. The line is delivered as a single-cycle pulse when a well-formed tail arrives. A flit that breaks the framing raises a single-cycle error flag, and the partial line is dropped.

The flit kind travels on two sideband wires next to the data wires. This means a body flit carries a full flit width of line data: a 64-byte line needs four body flits at 128 bits and eight at 64 bits. The routing, buffering and credit logic of a real network sits outside this block.

Top module: `cl_flit_link`

## Requirements
- R1: After a synchronous reset, `tx_valid_o`, `out_valid_o` and `frame_err_o` are 0 and `src_ready_o` is 1.
- R2: The first flit after a line is accepted has kind 2'b00 (head). With default parameters its data holds the destination tile in bits [5:0], the source core in bits [9:6] and the opcode in bit 10, with all higher bits 0.
- R3: The head flit is followed by LINE_W/FLIT_W body flits of kind 2'b01. They carry the line's least significant FLIT_W-bit slice first and then each next higher slice in turn.
- R4: The last flit of a packet has kind 2'b10 (tail) and all-zero data. When ready is held high the whole packet of LINE_W/FLIT_W+2 flits goes out on consecutive cycles, and `tx_valid_o` falls after the tail handshake. Kind 2'b11 is never sent.
- R5: While `tx_valid_o` is high and `tx_ready_i` is low, the kind and data of the presented flit hold unchanged in the next cycle. The sender advances only on a valid-and-ready cycle.
- R6: `src_ready_o` is low from the cycle after a line is accepted until the tail flit has been handed off. No new line is taken in that window.
- R7: In the cycle after a tail is accepted that follows a head and exactly LINE_W/FLIT_W bodies, `out_valid_o` is high for exactly one cycle. In that cycle it presents the rebuilt line and the head's destination, core and opcode.
- R8: A body or tail flit that arrives with no open packet raises `frame_err_o` for one cycle and produces no line.
- R9: A head flit that arrives while a packet is open raises `frame_err_o` and discards the partial line. That head then opens a fresh packet, which is delivered normally.
- R10: A tail that arrives after too few bodies, a body beyond LINE_W/FLIT_W, or a flit of kind 2'b11 raises `frame_err_o`, closes the packet and produces no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid_i | input | 1 | A line is offered for sending |
| src_ready_o | output | 1 | Sender is idle and takes the offered line |
| src_line_i | input | LINE_W | Cache line to send |
| src_dest_i | input | TILE_W | Destination tile id |
| src_core_i | input | CORE_W | Source core id |
| src_op_i | input | 1 | Opcode: 0 request, 1 response |
| tx_valid_o | output | 1 | Outgoing flit present |
| tx_ready_i | input | 1 | Link takes the outgoing flit |
| tx_kind_o | output | 2 | Outgoing flit kind |
| tx_data_o | output | FLIT_W | Outgoing flit data |
| rx_valid_i | input | 1 | Incoming flit present (always taken) |
| rx_kind_i | input | 2 | Incoming flit kind |
| rx_data_i | input | FLIT_W | Incoming flit data |
| out_valid_o | output | 1 | One-cycle pulse: rebuilt line present |
| out_line_o | output | LINE_W | Rebuilt cache line |
| out_dest_o | output | TILE_W | Destination tile id from the head |
| out_core_o | output | CORE_W | Source core id from the head |
| out_op_o | output | 1 | Opcode from the head |
| frame_err_o | output | 1 | One-cycle pulse on a framing violation |

## Verification
The assertions assume that `tx_ready_i` and the receive inputs may change freely from cycle to cycle. They also assume that the receive side sees at most one flit per cycle, so a delivered line and a framing error never coincide. In loopback the bench forwards the sender's flit to the receiver only on a valid-and-ready cycle, which matches what a real link would carry. Malformed trains are injected only while the sender is idle, one flit per cycle, so that the two sources never compete for the receive inputs.

// File: rtl/flit_pkg.sv
package flit_pkg;
  typedef enum logic [1:0] {
    KIND_HEAD = 2'b00,
    KIND_BODY = 2'b01,
    KIND_TAIL = 2'b10,
    KIND_BAD  = 2'b11
  } flit_kind_e;
endpackage

// File: rtl/cl_flit_tx.sv
module cl_flit_tx
  import flit_pkg::*;
#(
  parameter int LINE_W = 512,
  parameter int FLIT_W = 128,
  parameter int TILE_W = 6,
  parameter int CORE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_valid_i,
  output logic              src_ready_o,
  input  logic [LINE_W-1:0] src_line_i,
  input  logic [TILE_W-1:0] src_dest_i,
  input  logic [CORE_W-1:0] src_core_i,
  input  logic              src_op_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [1:0]        tx_kind_o,
  output logic [FLIT_W-1:0] tx_data_o
);
  localparam int NB    = LINE_W / FLIT_W;
  localparam int CW    = $clog2(NB + 2);
  localparam int HDR_W = TILE_W + CORE_W + 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(NB + 1);

  logic              busy_q;
  logic [CW-1:0]     idx_q;
  logic [LINE_W-1:0] shl_q;
  logic [HDR_W-1:0]  hdr_q;
  logic              take, fire, is_body;

  assign take    = src_valid_i & ~busy_q;
  assign fire    = busy_q & tx_ready_i;
  assign is_body = (idx_q != '0) && (idx_q != LAST_IDX);

  // control state: reset
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (fire) begin
      if (idx_q == LAST_IDX) busy_q <= 1'b0;
      else                   idx_q  <= idx_q + 1'b1;
    end
  end

  // payload state: no reset, shifted one slice per body handshake
  always_ff @(posedge clk) begin
    if (take) begin
      shl_q <= src_line_i;
      hdr_q <= {src_op_i, src_core_i, src_dest_i};
    end else if (fire && is_body) begin
      shl_q <= shl_q >> FLIT_W;
    end
  end

  always_comb begin
    if (idx_q == '0) begin
      tx_kind_o = KIND_HEAD;
      tx_data_o = FLIT_W'(hdr_q);
    end else if (idx_q == LAST_IDX) begin
      tx_kind_o = KIND_TAIL;
      tx_data_o = '0;
    end else begin
      tx_kind_o = KIND_BODY;
      tx_data_o = shl_q[FLIT_W-1:0];
    end
  end

  assign tx_valid_o  = busy_q;
  assign src_ready_o = ~busy_q;
endmodule

// File: rtl/cl_flit_rx.sv
module cl_flit_rx
  import flit_pkg::*;
#(
  parameter int LINE_W = 512,
  parameter int FLIT_W = 128,
  parameter int TILE_W = 6,
  parameter int CORE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid_i,
  input  logic [1:0]        rx_kind_i,
  input  logic [FLIT_W-1:0] rx_data_i,
  output logic              out_valid_o,
  output logic [LINE_W-1:0] out_line_o,
  output logic [TILE_W-1:0] out_dest_o,
  output logic [CORE_W-1:0] out_core_o,
  output logic              out_op_o,
  output logic              frame_err_o
);
  localparam int NB = LINE_W / FLIT_W;
  localparam int CW = $clog2(NB + 1);
  localparam logic [CW-1:0] FULL = CW'(NB);

  flit_kind_e    kind;
  logic          open_q;
  logic [CW-1:0] cnt_q;
  logic          body_take, head_take;

  assign kind      = flit_kind_e'(rx_kind_i);
  assign head_take = rx_valid_i && (kind == KIND_HEAD);
  assign body_take = rx_valid_i && (kind == KIND_BODY) && open_q && (cnt_q != FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q      <= 1'b0;
      cnt_q       <= '0;
      out_valid_o <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      frame_err_o <= 1'b0;
      if (rx_valid_i) begin
        unique case (kind)
          KIND_HEAD: begin
            frame_err_o <= open_q;
            open_q      <= 1'b1;
            cnt_q       <= '0;
          end
          KIND_BODY: begin
            if (!open_q) begin
              frame_err_o <= 1'b1;
            end else if (cnt_q == FULL) begin
              frame_err_o <= 1'b1;
              open_q      <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          KIND_TAIL: begin
            if (open_q && cnt_q == FULL) out_valid_o <= 1'b1;
            else                         frame_err_o <= 1'b1;
            open_q <= 1'b0;
          end
          default: begin
            frame_err_o <= 1'b1;
            open_q      <= 1'b0;
          end
        endcase
      end
    end
  end

  // payload: no reset; slices enter at the top and settle lowest-first
  always_ff @(posedge clk) begin
    if (head_take) begin
      out_dest_o <= rx_data_i[TILE_W-1:0];
      out_core_o <= rx_data_i[TILE_W+CORE_W-1:TILE_W];
      out_op_o   <= rx_data_i[TILE_W+CORE_W];
    end
    if (body_take) begin
      out_line_o <= {rx_data_i, out_line_o[LINE_W-1:FLIT_W]};
    end
  end
endmodule

// File: rtl/cl_flit_link.sv
module cl_flit_link #(
  parameter int LINE_W = 512,
  parameter int FLIT_W = 128,
  parameter int TILE_W = 6,
  parameter int CORE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_valid_i,
  output logic              src_ready_o,
  input  logic [LINE_W-1:0] src_line_i,
  input  logic [TILE_W-1:0] src_dest_i,
  input  logic [CORE_W-1:0] src_core_i,
  input  logic              src_op_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [1:0]        tx_kind_o,
  output logic [FLIT_W-1:0] tx_data_o,
  input  logic              rx_valid_i,
  input  logic [1:0]        rx_kind_i,
  input  logic [FLIT_W-1:0] rx_data_i,
  output logic              out_valid_o,
  output logic [LINE_W-1:0] out_line_o,
  output logic [TILE_W-1:0] out_dest_o,
  output logic [CORE_W-1:0] out_core_o,
  output logic              out_op_o,
  output logic              frame_err_o
);
  cl_flit_tx #(.LINE_W(LINE_W), .FLIT_W(FLIT_W), .TILE_W(TILE_W), .CORE_W(CORE_W)) u_tx (
    .clk(clk), .rst(rst),
    .src_valid_i(src_valid_i), .src_ready_o(src_ready_o), .src_line_i(src_line_i),
    .src_dest_i(src_dest_i), .src_core_i(src_core_i), .src_op_i(src_op_i),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
    .tx_kind_o(tx_kind_o), .tx_data_o(tx_data_o)
  );

  cl_flit_rx #(.LINE_W(LINE_W), .FLIT_W(FLIT_W), .TILE_W(TILE_W), .CORE_W(CORE_W)) u_rx (
    .clk(clk), .rst(rst),
    .rx_valid_i(rx_valid_i), .rx_kind_i(rx_kind_i), .rx_data_i(rx_data_i),
    .out_valid_o(out_valid_o), .out_line_o(out_line_o), .out_dest_o(out_dest_o),
    .out_core_o(out_core_o), .out_op_o(out_op_o), .frame_err_o(frame_err_o)
  );
endmodule

// File: rtl/cl_flit_link_checker.sv
module cl_flit_link_checker #(
  parameter int FLIT_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              src_valid_i,
  input logic              src_ready_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [1:0]        tx_kind_o,
  input logic [FLIT_W-1:0] tx_data_o,
  input logic              out_valid_o,
  input logic              frame_err_o
);
  a_r2_head_first: assert property (@(posedge clk) disable iff (rst)
    (src_valid_i && src_ready_o) |=> (tx_valid_o && tx_kind_o == 2'b00));

  a_r4_no_bad_kind: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> (tx_kind_o != 2'b11));

  a_r4_tail_ends: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && tx_ready_i && tx_kind_o == 2'b10) |=> !tx_valid_o);

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_kind_o) && $stable(tx_data_o)));

  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> !src_ready_o);

  a_r7_one_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |=> !out_valid_o);

  a_r8_excl: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> !frame_err_o);
endmodule

bind cl_flit_link cl_flit_link_checker #(.FLIT_W(FLIT_W)) u_chk (
  .clk(clk), .rst(rst), .src_valid_i(src_valid_i), .src_ready_o(src_ready_o),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_kind_o(tx_kind_o),
  .tx_data_o(tx_data_o), .out_valid_o(out_valid_o), .frame_err_o(frame_err_o)
);

// File: tb/cl_flit_link_bench.sv
module cl_flit_link_bench;
  localparam int LINE_W = 512;
  localparam int FLIT_W = 128;
  localparam int TILE_W = 6;
  localparam int CORE_W = 4;
  localparam int NB     = LINE_W / FLIT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              src_valid = 1'b0, src_ready, src_op = 1'b0;
  logic [LINE_W-1:0] src_line = '0;
  logic [TILE_W-1:0] src_dest = '0;
  logic [CORE_W-1:0] src_core = '0;
  logic              tx_valid, link_rdy = 1'b0;
  logic [1:0]        tx_kind;
  logic [FLIT_W-1:0] tx_data;
  logic              inj_on = 1'b0, inj_valid = 1'b0;
  logic [1:0]        inj_kind = '0;
  logic [FLIT_W-1:0] inj_data = '0;
  logic              rx_valid;
  logic [1:0]        rx_kind;
  logic [FLIT_W-1:0] rx_data;
  logic              out_valid, out_op, frame_err;
  logic [LINE_W-1:0] out_line;
  logic [TILE_W-1:0] out_dest;
  logic [CORE_W-1:0] out_core;

  assign rx_valid = inj_on ? inj_valid : (tx_valid & link_rdy);
  assign rx_kind  = inj_on ? inj_kind  : tx_kind;
  assign rx_data  = inj_on ? inj_data  : tx_data;

  cl_flit_link #(.LINE_W(LINE_W), .FLIT_W(FLIT_W), .TILE_W(TILE_W), .CORE_W(CORE_W)) u_cl_flit_link (
    .clk(clk), .rst(rst),
    .src_valid_i(src_valid), .src_ready_o(src_ready), .src_line_i(src_line),
    .src_dest_i(src_dest), .src_core_i(src_core), .src_op_i(src_op),
    .tx_valid_o(tx_valid), .tx_ready_i(link_rdy), .tx_kind_o(tx_kind), .tx_data_o(tx_data),
    .rx_valid_i(rx_valid), .rx_kind_i(rx_kind), .rx_data_i(rx_data),
    .out_valid_o(out_valid), .out_line_o(out_line), .out_dest_o(out_dest),
    .out_core_o(out_core), .out_op_o(out_op), .frame_err_o(frame_err)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [LINE_W-1:0] make_line(input int seed);
    logic [LINE_W-1:0] l;
    for (int i = 0; i < LINE_W / 32; i++)
      l[i*32 +: 32] = 32'(seed) * 32'h9E3779B1 + 32'(i) * 32'h01000193;
    return l;
  endfunction

  function automatic logic [FLIT_W-1:0] head_word(input logic [TILE_W-1:0] d, input logic [CORE_W-1:0] c, input logic o);
    return FLIT_W'(d) | (FLIT_W'(c) << 6) | (FLIT_W'(o) << 10);
  endfunction

  // loopback send with ready pattern: cycle c ready = 1 when c%4==3, else !pat[c%4]
  task automatic send_line(input int seed, input logic [TILE_W-1:0] d, input logic [CORE_W-1:0] c, input logic o, input logic [2:0] pat);
    logic [LINE_W-1:0] ln = make_line(seed);
    int k = 0;
    int cyc = 0;
    check(src_ready == 1'b1, "R6 idle ready", LINE_W'(src_ready), 1);
    src_line = ln; src_dest = d; src_core = c; src_op = o; src_valid = 1'b1;
    @(negedge clk);
    src_valid = 1'b0;
    src_line = ~ln;
    while (k < NB + 2) begin
      logic [1:0] ek;
      logic [FLIT_W-1:0] ed;
      logic rdy;
      if (k == 0) begin ek = 2'b00; ed = head_word(d, c, o); end
      else if (k == NB + 1) begin ek = 2'b10; ed = '0; end
      else begin ek = 2'b01; ed = ln[(k-1)*FLIT_W +: FLIT_W]; end
      check(tx_valid == 1'b1, "R5 valid held", LINE_W'(tx_valid), 1);
      check(tx_kind == ek, (k == 0) ? "R2 head kind" : (k == NB + 1) ? "R4 tail kind" : "R3 body kind", LINE_W'(tx_kind), LINE_W'(ek));
      check(tx_data == ed, (k == 0) ? "R2 head fields" : (k == NB + 1) ? "R4 tail data" : "R3 body slice", LINE_W'(tx_data), LINE_W'(ed));
      check(src_ready == 1'b0, "R6 busy blocks line", LINE_W'(src_ready), 0);
      rdy = (cyc % 4 == 3) ? 1'b1 : !pat[cyc % 4];
      link_rdy = rdy;
      @(negedge clk);
      if (rdy) k++;
      cyc++;
    end
    link_rdy = 1'b0;
    if (pat == 3'd0) check(cyc == NB + 2, "R4 back to back", LINE_W'(cyc), LINE_W'(NB + 2));
    check(tx_valid == 1'b0, "R4 valid falls after tail", LINE_W'(tx_valid), 0);
    check(out_valid == 1'b1, "R7 line valid", LINE_W'(out_valid), 1);
    check(out_line == ln, "R7 line data", out_line, ln);
    check({out_op, out_core, out_dest} == {o, c, d}, "R7 header", LINE_W'({out_op, out_core, out_dest}), LINE_W'({o, c, d}));
    check(frame_err == 1'b0, "R7 no error", LINE_W'(frame_err), 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 single pulse", LINE_W'(out_valid), 0);
    check(src_ready == 1'b1, "R6 ready again", LINE_W'(src_ready), 1);
  endtask

  task automatic inject(input logic [1:0] kd, input logic [FLIT_W-1:0] dt);
    inj_kind = kd; inj_data = dt; inj_valid = 1'b1;
    @(negedge clk);
    inj_valid = 1'b0;
  endtask

  task automatic expect_err(input string tag);
    check(frame_err == 1'b1, tag, LINE_W'(frame_err), 1);
    check(out_valid == 1'b0, tag, LINE_W'(out_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [LINE_W-1:0] lb;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(tx_valid == 1'b0, "R1 tx idle", LINE_W'(tx_valid), 0);
    check(src_ready == 1'b1, "R1 ready", LINE_W'(src_ready), 1);
    check(out_valid == 1'b0, "R1 no line", LINE_W'(out_valid), 0);
    check(frame_err == 1'b0, "R1 no error", LINE_W'(frame_err), 0);

    for (int p = 0; p < 8; p++)
      send_line(p + 1, TILE_W'(p * 9 + 5), CORE_W'(15 - p), p[0], 3'(p));

    inj_on = 1'b1;
    // R8: body and tail with no open packet
    inject(2'b01, '1);
    expect_err("R8 orphan body");
    @(negedge clk);
    check(frame_err == 1'b0, "R8 error is one cycle", LINE_W'(frame_err), 0);
    inject(2'b10, '0);
    expect_err("R8 orphan tail");

    // R9: head interrupts a partial packet, second packet delivered
    lb = make_line(77);
    inject(2'b00, head_word(6'd1, 4'd2, 1'b0));
    inject(2'b01, '1);
    inject(2'b01, '1);
    check(frame_err == 1'b0, "R9 partial ok so far", LINE_W'(frame_err), 0);
    inject(2'b00, head_word(6'd42, 4'd9, 1'b1));
    expect_err("R9 head before tail");
    for (int i = 0; i < NB; i++) inject(2'b01, lb[i*FLIT_W +: FLIT_W]);
    inject(2'b10, '0);
    check(out_valid == 1'b1, "R9 restarted packet delivered", LINE_W'(out_valid), 1);
    check(out_line == lb, "R9 partial discarded", out_line, lb);
    check({out_op, out_core, out_dest} == {1'b1, 4'd9, 6'd42}, "R9 new header", LINE_W'({out_op, out_core, out_dest}), LINE_W'({1'b1, 4'd9, 6'd42}));

    // R10: short packet, long packet, bad kind
    inject(2'b00, head_word(6'd3, 4'd3, 1'b0));
    for (int i = 0; i < NB - 1; i++) inject(2'b01, '0);
    inject(2'b10, '0);
    expect_err("R10 short packet");
    inject(2'b00, head_word(6'd3, 4'd3, 1'b0));
    for (int i = 0; i < NB; i++) inject(2'b01, '0);
    check(frame_err == 1'b0, "R10 full body count ok", LINE_W'(frame_err), 0);
    inject(2'b01, '0);
    expect_err("R10 extra body");
    inject(2'b10, '0);
    expect_err("R10 packet closed after extra body");
    inject(2'b11, '0);
    expect_err("R10 illegal kind");
    inj_on = 1'b0;
    @(negedge clk);

    send_line(200, 6'd63, 4'd0, 1'b1, 3'd5);
    report();
    $finish;
  end
endmodule